// File: doc/BRIEF.md
# Paged Serial Configuration Streamer

This block plays the read side of a serial configuration memory that loads an FPGA one bit per clock. It holds a byte address counter and a bit-within-byte counter. It shifts bytes out of an internal content array, most significant bit first, for as long as the chip enable (active low) is asserted and the combined reset/output-enable pin is high. Pulling that pin low returns both counters to the start of the active range and releases the data line at once.

The address space can be used whole, or split into four equal pages. When paging is on, a 2-bit select picks which quarter of the array is streamed. When the last bit of the active range has been shifted out, the block releases its data line and pulls its cascade output low, so that the next device in a chain can take over. The cascade output then follows a fixed rule tied to the chip enable and the output-enable pin.

A serial-enable input set low puts the block into programming mode, where no download takes place. A power-on reset holds a ready flag low for a set number of cycles. All control inputs are sampled on the rising clock edge. The reset input is synchronous and active low.

Top module: `cfg_page_streamer`

## Requirements
- R1: While `rst_n` is low, `ready` is 0 and `ceo_n` is 1. After `rst_n` has been sampled high on PWRUP_CYC rising edges, `ready` becomes 1 and stays 1 until the next reset.
- R2: The byte at address a is ((a mod 256)·29 + SEED) mod 256 XOR (a div 256 mod 256). While `data_oe` is 1, `data_out` shows bit (7 − bit index) of the current byte, so the most significant bit comes first. Each rising edge that samples `ce_n`=0 with `rstoe`=1 moves to the next bit. After bit index 7 comes bit index 0 of the next byte address.
- R3: While `rstoe` is 0, `data_oe` is 0 whatever `ce_n` is. An edge that samples `rstoe`=0 moves the counters to bit 0 of the first byte of the active range and clears the end-of-range state.
- R4: While `ce_n` is 1, `data_oe` is 0 and the counters hold their position. Streaming resumes from that same bit when `ce_n` returns to 0.
- R5: With `page_en`=1, the active range is bytes `page_sel`·DEPTH/4 to (`page_sel`+1)·DEPTH/4 − 1, where DEPTH is 2^ADDR_W. With `page_en`=0, the active range is bytes 0 to DEPTH − 1.
- R6: An edge that sees a page selection different from the one sampled on the previous edge moves the counters to bit 0 of the new range's first byte instead of advancing. This applies while `ser_en` is 1. When `page_en` is 0, `page_sel` does not count as part of the selection.
- R7: The edge that consumes bit 0 (the least significant bit) of the range's top byte ends the stream. From then on `data_oe` is 0 and the counters stop.
- R8: After the stream has ended, `ceo_n` equals `ce_n` while `rstoe` is 1. It is 1 while `rstoe` is 0, and it stays 1 until the range has been read through again.
- R9: While `ser_en` is 0, `data_oe` is 0 and `ceo_n` is 1. The counters hold, and `ce_n`, `rstoe`, `page_en` and `page_sel` have no effect.
- R10: While `ready` is 0, `data_oe` is 0 and the counters are held at the first byte of the selected range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial download clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ce_n | input | 1 | Chip enable, active low |
| rstoe | input | 1 | Low: reset the counters; high: enable the output |
| page_en | input | 1 | Splits the array into four pages |
| page_sel | input | 2 | Page chosen while paging is on |
| ser_en | input | 1 | High: streaming mode; low: programming mode (no download) |
| data_out | output | 1 | Serial configuration bit (0 when not driven) |
| data_oe | output | 1 | Drive enable for data_out |
| ceo_n | output | 1 | Cascade enable to the next device, active low |
| ready | output | 1 | High once the power-up delay has elapsed |

## Verification
The bench builds the block with ADDR_W=6, PWRUP_CYC=5 and SEED=A5h. That gives 64 bytes of content and 16-byte pages. With these values the whole array (512 bits) and each page (128 bits) can be streamed to the end within a few hundred cycles. This brings the end-of-range handoff and the cascade-output rule within reach for every page and for the unpaged range, along with the power-up delay edge.

// File: rtl/cfgs_pkg.sv
// Package: shared types and content function for the configuration streamer.
// Assumes byte addresses fit in 32 bits.
package cfgs_pkg;

    // Canonical page selection: sel is forced to 0 when paging is off
    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } page_cfg_t;

    // Content of the byte at address a for a given seed
    function automatic logic [7:0] cfgs_content(input int unsigned a, input logic [7:0] seed);
        logic [15:0] prod;
        prod = 16'(a & 32'd255) * 16'd29 + 16'(seed);
        return prod[7:0] ^ 8'((a >> 8) & 32'd255);
    endfunction

endpackage

// File: rtl/cfgs_rom.sv
// Module: content array and bit selector.
// Builds a 2^ADDR_W byte array from the package content function and picks
// one bit, most significant first. Assumes bit_idx counts 0..7 within a byte.
module cfgs_rom
    import cfgs_pkg::*;
#(
    parameter int         ADDR_W = 10,
    parameter logic [7:0] SEED   = 8'h5A
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [2:0]        bit_idx,
    output logic              bit_val
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] rom [DEPTH];

    // One constant entry per address
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = cfgs_content(i, SEED);
    end

    // Select the current bit, MSB at bit index 0
    always_comb begin
        bit_val = rom[byte_addr][3'd7 - bit_idx];
    end

endmodule

// File: rtl/cfgs_powerup.sv
// Module: power-up delay.
// Holds ready low for PWRUP_CYC edges after the synchronous reset is released.
module cfgs_powerup #(
    parameter int PWRUP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(PWRUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PWRUP_CYC);

    logic [CW-1:0] cnt;

    // Count reset-free edges up to the limit, then saturate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIMIT);

endmodule

// File: rtl/cfgs_addr_seq.sv
// Module: address and bit sequencer.
// Keeps the byte address and bit index, reloads the range base on reset,
// on output-enable low, during power-up and on a page change. Advances while
// enabled and stops after the top byte. Assumes pg is already canonical.
module cfgs_addr_seq
    import cfgs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              ser_en,
    input  logic              ce_n,
    input  logic              oe,
    input  page_cfg_t         pg,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_idx,
    output logic              done
);
    localparam int PAGE_W = ADDR_W - 2;

    page_cfg_t         sel_q;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] top_addr;
    logic              reload;

    // First and last byte of the active range
    always_comb begin
        if (pg.en) begin
            base_addr = {pg.sel, {PAGE_W{1'b0}}};
            top_addr  = {pg.sel, {PAGE_W{1'b1}}};
        end else begin
            base_addr = '0;
            top_addr  = '1;
        end
    end

    // Any condition that returns the counters to the range base
    assign reload = !ready || !oe || (pg != sel_q);

    // Counter update; frozen entirely in programming mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_addr <= '0;
            bit_idx   <= '0;
            done      <= 1'b0;
            sel_q     <= '0;
        end else if (ser_en) begin
            sel_q <= pg;
            if (reload) begin
                byte_addr <= base_addr;
                bit_idx   <= '0;
                done      <= 1'b0;
            end else if (!ce_n && !done) begin
                if (bit_idx == 3'd7) begin
                    bit_idx <= '0;
                    if (byte_addr == top_addr) begin
                        done <= 1'b1;
                    end else begin
                        byte_addr <= byte_addr + 1'b1;
                    end
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfgs_cascade.sv
// Module: output-enable and cascade-enable decode.
// Drives the data line only when ready, streaming, enabled and not finished.
// The cascade output tracks the chip enable after the range end until the
// output-enable pin drops. Purely combinational on its inputs.
module cfgs_cascade (
    input  logic ready,
    input  logic ser_en,
    input  logic ce_n,
    input  logic oe,
    input  logic done,
    output logic data_oe,
    output logic ceo_n
);
    // Data drive and cascade enable
    always_comb begin
        data_oe = ready && ser_en && oe && !ce_n && !done;
        ceo_n   = (ser_en && done && oe) ? ce_n : 1'b1;
    end

endmodule

// File: rtl/cfg_page_streamer.sv
// Module: paged serial configuration streamer (top).
// Streams a parameterised content array one bit per clock, with an optional
// four-page split, a combined reset/output-enable, cascade output and a
// power-up ready flag. All control inputs are sampled on clk; rst_n is
// synchronous, active low.
module cfg_page_streamer
    import cfgs_pkg::*;
#(
    parameter int         ADDR_W    = 10,
    parameter int         PWRUP_CYC = 16,
    parameter logic [7:0] SEED      = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       rstoe,
    input  logic       page_en,
    input  logic [1:0] page_sel,
    input  logic       ser_en,
    output logic       data_out,
    output logic       data_oe,
    output logic       ceo_n,
    output logic       ready
);
    page_cfg_t         pg_now;
    logic [ADDR_W-1:0] seq_addr;
    logic [2:0]        seq_bit;
    logic              seq_done;
    logic              rom_bit;

    // Canonical selection so page_sel is ignored when paging is off
    always_comb begin
        pg_now.en  = page_en;
        pg_now.sel = page_en ? page_sel : 2'b00;
    end

    cfgs_powerup #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    cfgs_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .ser_en    (ser_en),
        .ce_n      (ce_n),
        .oe        (rstoe),
        .pg        (pg_now),
        .byte_addr (seq_addr),
        .bit_idx   (seq_bit),
        .done      (seq_done)
    );

    cfgs_rom #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
        .byte_addr (seq_addr),
        .bit_idx   (seq_bit),
        .bit_val   (rom_bit)
    );

    cfgs_cascade u_csc (
        .ready   (ready),
        .ser_en  (ser_en),
        .ce_n    (ce_n),
        .oe      (rstoe),
        .done    (seq_done),
        .data_oe (data_oe),
        .ceo_n   (ceo_n)
    );

    assign data_out = data_oe & rom_bit;

endmodule

// File: rtl/cfgs_checker.sv
// Module: property checker for cfg_page_streamer, attached by bind.
// Observes ports and the sequencer outputs visible at the top level.
module cfgs_checker
    import cfgs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              rstoe,
    input logic              ser_en,
    input logic              data_oe,
    input logic              ceo_n,
    input logic              ready,
    input page_cfg_t         pg_now,
    input logic [ADDR_W-1:0] seq_addr,
    input logic [2:0]        seq_bit,
    input logic              seq_done
);
    // R1: ready never drops outside reset
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3: an output-enable low edge clears the bit index and the end state
    a_r3_oe_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !rstoe) |=> (seq_bit == 3'd0) && !seq_done);

    // R3: no drive while output-enable is low
    a_r3_oe_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        !rstoe |-> !data_oe);

    // R4: standby edges leave the counters untouched
    a_r4_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ser_en && rstoe && ce_n && $past(ser_en) && $stable(pg_now))
        |=> $stable(seq_addr) && $stable(seq_bit));

    // R2: an enabled edge steps the bit index by one inside a byte
    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ser_en && rstoe && !ce_n && !seq_done && $past(ser_en)
         && $stable(pg_now) && seq_bit != 3'd7)
        |=> seq_bit == $past(seq_bit) + 3'd1);

    // R7: cascade low and data drive never overlap
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n |-> !data_oe);

    // R9: programming mode is silent
    a_r9_isp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!data_oe && ceo_n));

    // R10: no drive before ready
    a_r10_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !data_oe);

endmodule

bind cfg_page_streamer cfgs_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cfg_page_streamer.sv
// Bench: scoreboard. Driver tasks push expected bits into a queue; the monitor
// pops and compares one bit for every cycle the data line is driven.
module sim_cfg_page_streamer;
    localparam int         AW    = 6;
    localparam int         PWR   = 5;
    localparam logic [7:0] SD    = 8'hA5;
    localparam int         DEPTH = 1 << AW;
    localparam int         PG    = DEPTH / 4;

    logic       clk = 1'b0;
    logic       rst_n, ce_n, rstoe, page_en, ser_en;
    logic [1:0] page_sel;
    logic       data_out, data_oe, ceo_n, ready;

    int checks = 0;
    int fails  = 0;
    logic exp_q[$];

    always #4 clk = ~clk;

    cfg_page_streamer #(.ADDR_W(AW), .PWRUP_CYC(PWR), .SEED(SD)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rstoe(rstoe),
        .page_en(page_en), .page_sel(page_sel), .ser_en(ser_en),
        .data_out(data_out), .data_oe(data_oe), .ceo_n(ceo_n), .ready(ready)
    );

    // Expected content byte, from the formula in R2
    function automatic int exp_byte(input int a);
        return (((a % 256) * 29 + int'(SD)) % 256) ^ ((a / 256) % 256);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Push count bits of the range starting at byte base, from bit offset first
    task automatic push_bits(input int base, input int first, input int count);
        for (int k = 0; k < count; k++) begin
            int idx = first + k;
            int b   = exp_byte(base + idx / 8);
            exp_q.push_back(1'((b >> (7 - idx % 8)) & 1));
        end
    endtask

    // Monitor: compare each driven bit against the scoreboard (R2)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (data_oe === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected drive", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk("R2 stream bit", int'(data_out), int'(e));
                end
            end
        end
    end

    task automatic restart(input logic en, input logic [1:0] sel);
        @(negedge clk); ce_n = 1'b1; rstoe = 1'b0; page_en = en; page_sel = sel;
        @(negedge clk); rstoe = 1'b1;
    endtask

    task automatic stream(input int n);
        @(negedge clk); ce_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic end_check(input string tag);
        @(negedge clk); ce_n = 1'b0;
        #2;
        chk({tag, " R7 data released at end"}, int'(data_oe), 0);
        chk({tag, " R7 ceo low at end"}, int'(ceo_n), 0);
        chk({tag, " R5 all range bits seen"}, exp_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; ser_en = 1'b1; rstoe = 1'b1; ce_n = 1'b0;
        page_en = 1'b0; page_sel = 2'b00;
        push_bits(0, 0, DEPTH * 8);
        repeat (3) @(negedge clk);
        #2;
        chk("R1 ready low in reset", int'(ready), 0);
        chk("R1 ceo high in reset", int'(ceo_n), 1);
        chk("R10 no drive in reset", int'(data_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (PWR - 1) @(negedge clk);
        #2;
        chk("R1 ready low one cycle early", int'(ready), 0);
        chk("R10 no drive before ready", int'(data_oe), 0);
        @(negedge clk); #2;
        chk("R1 ready after delay", int'(ready), 1);
        chk("R10 drive starts at base", int'(data_oe), 1);
        repeat (255) @(negedge clk);
        #2;
        chk("R7 ceo high mid stream", int'(ceo_n), 1);
        repeat (257) @(negedge clk);
        #2;
        chk("R5 R7 full range end data", int'(data_oe), 0);
        chk("R7 full range end ceo", int'(ceo_n), 0);
        chk("R5 full range consumed", exp_q.size(), 0);

        // R8: cascade output rule
        @(negedge clk); ce_n = 1'b1; #2;
        chk("R8 ceo follows ce high", int'(ceo_n), 1);
        @(negedge clk); ce_n = 1'b0; #2;
        chk("R8 ceo follows ce low", int'(ceo_n), 0);
        @(negedge clk); ce_n = 1'b1; rstoe = 1'b0; #2;
        chk("R8 ceo high with oe low", int'(ceo_n), 1);
        @(negedge clk); rstoe = 1'b1; #2;
        chk("R8 ceo stays high after oe", int'(ceo_n), 1);
        chk("R4 standby no drive", int'(data_oe), 0);

        // R5: page 2
        restart(1'b1, 2'd2);
        push_bits(2 * PG, 0, PG * 8);
        stream(PG * 8);
        end_check("R5 page2");

        // R4: standby hold mid stream on page 1
        restart(1'b1, 2'd1);
        push_bits(PG, 0, PG * 8);
        stream(40);
        repeat (5) begin
            @(negedge clk); #2;
            chk("R4 no drive in standby", int'(data_oe), 0);
        end
        stream(PG * 8 - 40);
        end_check("R4 page1");

        // R3: output-enable reset mid stream on page 3, with ce_n low
        restart(1'b1, 2'd3);
        push_bits(3 * PG, 0, 20);
        stream(20);
        push_bits(3 * PG, 0, PG * 8);
        @(negedge clk); ce_n = 1'b0; rstoe = 1'b0; #2;
        chk("R3 no drive with oe low", int'(data_oe), 0);
        @(negedge clk); rstoe = 1'b1;
        repeat (PG * 8) @(negedge clk);
        ce_n = 1'b1;
        end_check("R3 page3");

        // R6: page change reloads the new base
        restart(1'b1, 2'd0);
        push_bits(0, 0, 24);
        stream(24);
        @(negedge clk); page_sel = 2'd1; #2;
        chk("R6 no drive during change", int'(data_oe), 0);
        push_bits(PG, 0, PG * 8);
        stream(PG * 8);
        end_check("R6 page1");

        // R9: programming mode ignores controls and resumes in place
        restart(1'b1, 2'd0);
        push_bits(0, 0, 10);
        stream(10);
        push_bits(0, 10, PG * 8 - 10);
        @(negedge clk); ser_en = 1'b0; ce_n = 1'b0; #2;
        chk("R9 no drive in isp", int'(data_oe), 0);
        chk("R9 ceo high in isp", int'(ceo_n), 1);
        @(negedge clk); rstoe = 1'b0; #2;
        chk("R9 no drive isp oe low", int'(data_oe), 0);
        @(negedge clk); rstoe = 1'b1; page_sel = 2'd3; page_en = 1'b0; #2;
        chk("R9 no drive isp page change", int'(data_oe), 0);
        @(negedge clk); page_sel = 2'd0; page_en = 1'b1; #2;
        chk("R9 ceo high isp", int'(ceo_n), 1);
        @(negedge clk); ser_en = 1'b1;
        repeat (PG * 8 - 10) @(negedge clk);
        ce_n = 1'b1;
        end_check("R9 page0");

        @(negedge clk); #2;
        chk("R2 scoreboard empty", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule